// File: doc/BRIEF.md
# PHY Management Serial Master

This block is the master side of the two-wire management link used to read and write the registers of an Ethernet PHY. Software writes one 32-bit maintenance word that holds every field of the frame. That single write starts the transaction at once. The block prefixes the word with a preamble of ones and shifts it out on the data line, one bit per cycle of a management clock. The management clock is made by dividing the system clock. For a read, the block lets go of the data line for the turnaround and data bits. It collects the 16 bits the PHY returns and puts them into the low half of the same maintenance word, where software reads them.

An idle flag tells software when it may write the next word. The management clock sits low and does not move between transactions. The half period of that clock is a per-transaction input. A zero on that input selects a built-in default that keeps the management clock at or below 2.5 MHz from a 250 MHz system clock. The tristate pad and the PHY are outside the block. The block gives out a data value and an output-enable, and it takes in the value on the pad.

Top module: `mdio_master`

## Requirements
- R1: A write pulse on `wrEn` while `idle` is high starts a transaction. From the next clock edge, `idle` is low and `maintReg` shows the written word.
- R2: A transaction makes exactly 64 rising edges of `mdc`. The bit sent at each rising edge is 32 ones followed by `maintReg` bits 31 down to 0. The word layout is: start code in [31:30] (01), opcode in [29:28] (01 write, 10 read), PHY address in [27:23], register address in [22:18], turnaround in [17:16], data in [15:0].
- R3: Each `mdc` high phase lasts H system clocks, and each low phase also lasts H clocks. H is the value on `mdcHalfPeriod` when the write is accepted. A value of 0 selects H = 50.
- R4: While `idle` is high, `mdc` stays low.
- R5: `mdioOut` changes only at the edge where `mdc` falls, or at the start of a transaction. It never changes while `mdc` is high.
- R6: For a read (opcode 10), `mdioOe` is low for bits 46 to 63 of the frame, which are the turnaround and the data. The value on `mdioIn` at each of the last 16 rising edges is shifted into `maintReg[15:0]`, first bit into bit 15. `maintReg[31:16]` is left unchanged.
- R7: A write pulse while `idle` is low is ignored. Neither `maintReg` nor the bits being sent change.
- R8: `idle` rises again exactly 128·H clocks after the write is accepted, at the edge where `mdc` falls for the 64th time. After that, `mdioOe` is low.
- R9: For a write (opcode 01), `mdioOe` is high for all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the maintenance word |
| wrData | input | 32 | Maintenance word to write |
| mdcHalfPeriod | input | 8 | Half period of `mdc` in system clocks (0 selects the default) |
| maintReg | output | 32 | Current maintenance word, including captured read data |
| idle | output | 1 | High when no transaction is in flight |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value to drive on the data pad |
| mdioOe | output | 1 | Output enable for the data pad |
| mdioIn | input | 1 | Value seen on the data pad |

## Verification
The assertions assume that `wrEn` is a clean, synchronous pulse. They also assume that `mdioIn` is stable around each clock edge, so a value presented after a falling `mdc` edge is still there at the next rising edge. The bench's PHY model updates `mdioIn` only between clock edges, in step with its own count of rising `mdc` edges. The bench changes inputs only just after a rising clock edge. It uses half periods from 1 to 6 plus the default, and it fires its stray write pulses early in a frame, before any read data arrives.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int WORD_BITS  = 32;
  localparam int FRAME_BITS = PRE_BITS + WORD_BITS;
  localparam int TURN_OFS   = 14;   // turnaround position inside the word
  localparam int DATA_OFS   = 16;   // data position inside the word
  localparam int DATA_BITS  = 16;
  localparam logic [1:0] OP_READ = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // accept new maintenance word
    logic shift;    // advance to the next bit (falling mdc)
    logic sample;   // rising mdc: sample the pad
    logic busy;     // frame in flight
    logic inTurn;   // in turnaround or data bits
    logic inData;   // in data bits
  } mdioStrb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_W       = 8,
  parameter int DEFAULT_HALF = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [HALF_W-1:0] halfSel,
  output logic              mdc,
  output logic              idle,
  output mdioStrb_t         strb
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TURN_BIT  = CNT_W'(PRE_BITS + TURN_OFS);
  localparam logic [CNT_W-1:0] DATA_BIT  = CNT_W'(PRE_BITS + DATA_OFS);
  localparam logic [HALF_W-1:0] DEF_HALF = HALF_W'(DEFAULT_HALF);

  logic              busy;
  logic              mdcQ;
  logic [HALF_W-1:0] halfLim;
  logic [HALF_W-1:0] halfCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic              tick;
  logic              accept;
  logic [HALF_W-1:0] halfEff;

  assign accept  = wrEn && !busy;
  assign tick    = busy && (halfCnt == halfLim);
  assign halfEff = (halfSel == '0) ? DEF_HALF : halfSel;

  always_comb begin
    strb        = '0;
    strb.load   = accept;
    strb.busy   = busy;
    strb.sample = tick && !mdcQ;
    strb.shift  = tick && mdcQ && (bitCnt != LAST_BIT);
    strb.inTurn = bitCnt >= TURN_BIT;
    strb.inData = bitCnt >= DATA_BIT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      mdcQ    <= 1'b0;
      halfLim <= '0;
      halfCnt <= '0;
      bitCnt  <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      mdcQ    <= 1'b0;
      halfLim <= halfEff - 1'b1;
      halfCnt <= '0;
      bitCnt  <= '0;
    end else if (busy) begin
      if (tick) begin
        halfCnt <= '0;
        mdcQ    <= ~mdcQ;
        if (mdcQ) begin
          if (bitCnt == LAST_BIT) busy <= 1'b0;
          else                    bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  assign mdc  = mdcQ;
  assign idle = !busy;

  assert_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idle) |=> !idle);
  assert_mdc_static_R4: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !mdc);
  assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idle) |-> (!mdc && $past(mdc)));
  assert_mdc_steps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick && !accept) |=> $stable(mdc));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WORD_BITS-1:0] wrData,
  input  mdioStrb_t            strb,
  input  logic                 mdioIn,
  output logic [WORD_BITS-1:0] maintReg,
  output logic                 mdioOut,
  output logic                 mdioOe
);
  logic [WORD_BITS-1:0]  maintQ;
  logic [FRAME_BITS-1:0] shiftQ;
  logic                  isRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maintQ <= '0;
      shiftQ <= '0;
      isRead <= 1'b0;
    end else if (strb.load) begin
      maintQ <= wrData;
      shiftQ <= {{PRE_BITS{1'b1}}, wrData};
      isRead <= (wrData[WORD_BITS-3 -: 2] == OP_READ);
    end else begin
      if (strb.shift)
        shiftQ <= {shiftQ[FRAME_BITS-2:0], 1'b0};
      if (strb.sample && strb.inData && isRead)
        maintQ[DATA_BITS-1:0] <= {maintQ[DATA_BITS-2:0], mdioIn};
    end
  end

  assign maintReg = maintQ;
  assign mdioOut  = strb.busy && shiftQ[FRAME_BITS-1];
  assign mdioOe   = strb.busy && !(isRead && strb.inTurn);

  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !strb.sample) |=> $stable(maintQ));
  assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |=> $stable(maintQ[WORD_BITS-1:DATA_BITS]));
  assert_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sample && strb.inData && isRead) |-> !mdioOe);
  assert_out_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.shift && !strb.load) |=> $stable(shiftQ));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_W       = 8,
  parameter int DEFAULT_HALF = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic [HALF_W-1:0] mdcHalfPeriod,
  output logic [31:0]       maintReg,
  output logic              idle,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mdioStrb_t strb;

  mdio_ctrl #(.HALF_W(HALF_W), .DEFAULT_HALF(DEFAULT_HALF)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .halfSel(mdcHalfPeriod),
    .mdc(mdc), .idle(idle), .strb(strb)
  );

  mdio_datapath i_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strb(strb), .mdioIn(mdioIn),
    .maintReg(maintReg), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [7:0]  mdcHalfPeriod = '0;
  logic [31:0] maintReg;
  logic        idle, mdc, mdioOut, mdioOe, mdioIn;

  always #2 clk = ~clk;   // 250 MHz

  mdio_master i_mdio_master (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .mdcHalfPeriod(mdcHalfPeriod), .maintReg(maintReg), .idle(idle),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // Monitor / PHY model state
  logic [15:0] phyReadVal = '0;
  int          curHalf = 1;
  int          rises, busyCnt, highRun, widthBad, outChgHigh, idleMdcBad;
  logic [63:0] capBits, oeBits;
  logic        prevMdc = 1'b0, prevOut = 1'b0;

  initial begin
    rises = 0; busyCnt = 0; highRun = 0; widthBad = 0; outChgHigh = 0;
    idleMdcBad = 0; capBits = '0; oeBits = '0;
  end

  // PHY drives read data for frame bits 48..63, pull-up otherwise
  assign mdioIn = (rises >= 48 && rises < 64) ? phyReadVal[63 - rises] : 1'b1;

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (wrEn && idle) begin
      rises <= 0; busyCnt <= 0; highRun <= 0; widthBad <= 0; outChgHigh <= 0;
      capBits <= '0; oeBits <= '0;
    end else begin
      if (!idle) busyCnt <= busyCnt + 1;
      if (idle && mdc) idleMdcBad <= idleMdcBad + 1;
      if (mdc && !prevMdc && rises < 64) begin
        capBits[63 - rises] <= mdioOut;
        oeBits[63 - rises]  <= mdioOe;
        rises <= rises + 1;
      end
      if (mdc && prevMdc && (mdioOut != prevOut)) outChgHigh <= outChgHigh + 1;
      if (mdc) highRun <= highRun + 1;
      else if (prevMdc) begin
        if (highRun != curHalf) widthBad <= widthBad + 1;
        highRun <= 0;
      end
    end
    prevMdc <= mdc;
    prevOut <= mdioOut;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input logic [31:0] w);
    return {32'hFFFF_FFFF, w};
  endfunction

  function automatic bit isRd(input logic [31:0] w);
    return w[29:28] == 2'b10;
  endfunction

  function automatic logic [63:0] expOe(input logic [31:0] w);
    return isRd(w) ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  function automatic logic [31:0] expFinal(input logic [31:0] w, input logic [15:0] rd);
    return isRd(w) ? {w[31:16], rd} : w;
  endfunction

  task automatic doFrame(input logic [31:0] w, input logic [7:0] hsel,
                         input logic [15:0] rd, input bit poke);
    int guard;
    curHalf = (hsel == 0) ? 50 : int'(hsel);
    @(posedge clk); #1;
    mdcHalfPeriod = hsel; wrData = w; wrEn = 1'b1; phyReadVal = rd;
    @(posedge clk); #1;
    wrEn = 1'b0; mdcHalfPeriod = 8'd7;   // later changes must not matter (R3)
    @(negedge clk);
    chk(!idle && maintReg == w, "R1 start", {31'b0, idle, maintReg}, {32'b0, w});
    if (poke) begin
      repeat (5) @(posedge clk);
      #1 wrEn = 1'b1; wrData = ~w;
      @(posedge clk); #1 wrEn = 1'b0;
      @(negedge clk);
      chk(maintReg == w && !idle, "R7 busy write ignored", {32'b0, maintReg}, {32'b0, w});
    end
    guard = 0;
    while (!idle && guard < 20000) begin @(negedge clk); guard++; end
    chk(busyCnt == 128 * curHalf, "R8 frame length", 64'(busyCnt), 64'(128 * curHalf));
    chk(rises == 64, "R2 mdc pulse count", 64'(rises), 64'd64);
    if (isRd(w))
      chk(capBits[63:18] == expFrame(w)[63:18], "R2 read header bits",
          capBits, expFrame(w));
    else
      chk(capBits == expFrame(w), "R2 write frame bits", capBits, expFrame(w));
    chk(oeBits == expOe(w), isRd(w) ? "R6 read release" : "R9 write drive",
        oeBits, expOe(w));
    chk(widthBad == 0, "R3 mdc high width", 64'(widthBad), 64'd0);
    chk(outChgHigh == 0, "R5 mdio stable while mdc high", 64'(outChgHigh), 64'd0);
    chk(maintReg == expFinal(w, rd), "R6 maintenance word after frame",
        {32'b0, maintReg}, {32'b0, expFinal(w, rd)});
    chk(!mdioOe && !mdc, "R8 bus released at end", {62'b0, mdioOe, mdc}, 64'd0);
    repeat (3) @(negedge clk);
    chk(idleMdcBad == 0 && !mdc, "R4 mdc quiet while idle", 64'(idleMdcBad), 64'd0);
  endtask

  function automatic logic [31:0] mkWord(input bit rd, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, rd ? 2'b10 : 2'b01, phy, rg, rd ? 2'b11 : 2'b10, d};
  endfunction

  initial begin : watchdog
    wait (cycles > 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(idle && !mdc && !mdioOe && maintReg == 0, "R4 reset state",
        {29'b0, idle, mdc, mdioOe, maintReg}, {29'b0, 3'b100, 32'b0});
    #1 rstN = 1'b1;
    // Directed corners
    doFrame(mkWord(1'b0, 5'h1F, 5'h00, 16'hA5C3), 8'd1, 16'h0000, 1'b0);
    doFrame(mkWord(1'b1, 5'h00, 5'h1F, 16'h0000), 8'd2, 16'hFFFF, 1'b1);
    doFrame(mkWord(1'b1, 5'h05, 5'h02, 16'h1234), 8'd0, 16'h8001, 1'b0);
    doFrame(mkWord(1'b0, 5'h0A, 5'h15, 16'h0000), 8'd3, 16'hFFFF, 1'b1);
    // Random frames
    for (int i = 0; i < 24; i++) begin
      logic [31:0] r;
      r = $urandom;
      doFrame(mkWord(r[0], r[5:1], r[10:6], $urandom),
              8'(1 + ($urandom % 6)), 16'($urandom), r[11]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule